// File: doc/BRIEF.md
# Rotating Priority Resolver with Nesting

This block decides which of eight interrupt request lines, if any, should be presented to the processor. It works from four inputs: the pending requests, a mask, the lines currently in service, and a 3-bit rotation base. Priorities rotate around the base. The line equal to the base ranks first, and the ranking descends through the following line numbers and wraps around. A candidate wins only when it strictly outranks the best line already in service. This gives nested servicing, where a lower or equal request waits until the line ahead of it is cleared.

When the instance is configured as the primary controller in a cascade, a nesting flag can exempt the cascade line's in-service bit from the in-service ranking. The secondary controller can then still raise further requests through that line while one of its own requests is in service. A second, independent ranking port returns the highest-priority set bit of any vector under the same rotation. End-of-interrupt logic uses it to find which in-service bit to clear. The resolver itself is combinational. Its result is also copied into a registered interrupt output toward the processor.

Top module: `nest_prio_resolver`

## Requirements
- R1: Line n has rank (n - base) mod 8, where rank 0 is the best. Among the candidate lines, the one with the smallest rank is reported on winLine.
- R2: The candidates are the bits of pendVec with the maskVec bits removed. When no candidate exists, winValid is 0.
- R3: A line whose maskVec bit is 1, or whose pendVec bit is 0, is never reported with winValid = 1.
- R4: winValid is 1 only if the winning candidate's rank is strictly smaller than the rank of the best in-service line. An equal or worse rank gives winValid = 0.
- R5: An all-zero in-service vector has the "none" rank of 8. Any candidate then wins.
- R6: With IS_PRIMARY = 1 and nestMode = 1, svcVec bit CASCADE_LINE (default 2) is left out of the in-service ranking. With nestMode = 0 that bit counts like any other.
- R7: probeValid is 1 exactly when probeVec is non-zero. probeLine is then the set bit of probeVec with the smallest rank under the same base.
- R8: intReq is 0 while rstN is low. Each cycle after reset, intReq takes the value winValid had before the previous rising clock edge.
- R9: R1 and R7 hold for every one of the eight base values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pendVec | input | 8 | Pending request bits, one per line |
| maskVec | input | 8 | Mask bits; 1 blocks the line |
| svcVec | input | 8 | In-service bits |
| rotBase | input | 3 | Line number that holds rank 0 |
| nestMode | input | 1 | Exempt the cascade line from in-service ranking (primary only) |
| probeVec | input | 8 | Arbitrary vector for the ranking helper |
| winValid | output | 1 | A candidate outranks everything in service |
| winLine | output | 3 | Line number of the winning candidate |
| probeValid | output | 1 | probeVec has at least one set bit |
| probeLine | output | 3 | Best-ranked set bit of probeVec |
| intReq | output | 1 | Registered interrupt request toward the processor |

## Verification
The directed patterns come first. A lone candidate on each line separates a correct rank rotation from an off-by-one or reversed rotation. A fully pending vector with a single unmasked line shows that the mask is applied before ranking. In-service bits placed at the same rank, a better rank and a worse rank as the candidate separate strict comparison from non-strict comparison. The cascade bit in service, with nestMode off and then on, separates the exemption from an unconditional one. After that, a long pseudo-random sweep over all eight base values compares winner, helper and the registered output with a loop model that ranks each line directly by its rank formula.

// File: rtl/pri_pkg.sv
package pri_pkg;
  localparam int PRI_IDX_W = 3;
  localparam int PRI_LINES = 1 << PRI_IDX_W;
  localparam int PRI_RANK_W = PRI_IDX_W + 1;

  typedef struct packed {
    logic                  hit;
    logic [PRI_RANK_W-1:0] rank;
    logic [PRI_IDX_W-1:0]  line;
  } rank_t;

  typedef struct packed {
    logic exemptCascade;
    logic loadInt;
  } ctrl_strobe_t;
endpackage

// File: rtl/pri_ranker.sv
module pri_ranker
  import pri_pkg::*;
(
  input  logic [PRI_LINES-1:0] vec,
  input  logic [PRI_IDX_W-1:0] base,
  output rank_t                result
);
  logic [PRI_IDX_W-1:0] idx;

  always_comb begin
    result.hit  = 1'b0;
    result.rank = PRI_RANK_W'(PRI_LINES);
    result.line = '0;
    idx         = '0;
    for (int k = PRI_LINES - 1; k >= 0; k--) begin
      idx = base + PRI_IDX_W'(k);
      if (vec[idx]) begin
        result.hit  = 1'b1;
        result.rank = PRI_RANK_W'(k);
        result.line = idx;
      end
    end
  end
endmodule

// File: rtl/pri_datapath.sv
module pri_datapath
  import pri_pkg::*;
#(
  parameter int CASCADE_LINE = 2
) (
  input  logic [PRI_LINES-1:0] pendVec,
  input  logic [PRI_LINES-1:0] maskVec,
  input  logic [PRI_LINES-1:0] svcVec,
  input  logic [PRI_LINES-1:0] probeVec,
  input  logic [PRI_IDX_W-1:0] rotBase,
  input  ctrl_strobe_t         strobes,
  output rank_t                candRank,
  output rank_t                svcRank,
  output rank_t                probeRank
);
  localparam int NUM_RANKERS = 3;
  localparam logic [PRI_LINES-1:0] CASCADE_BIT = PRI_LINES'(1) << CASCADE_LINE;

  logic [PRI_LINES-1:0] rankIn [NUM_RANKERS];
  rank_t                rankOut [NUM_RANKERS];

  always_comb begin
    rankIn[0] = pendVec & ~maskVec;
    rankIn[1] = strobes.exemptCascade ? (svcVec & ~CASCADE_BIT) : svcVec;
    rankIn[2] = probeVec;
  end

  for (genvar g = 0; g < NUM_RANKERS; g++) begin : g_rank
    pri_ranker u_rank (
      .vec    (rankIn[g]),
      .base   (rotBase),
      .result (rankOut[g])
    );
  end

  assign candRank  = rankOut[0];
  assign svcRank   = rankOut[1];
  assign probeRank = rankOut[2];
endmodule

// File: rtl/pri_ctrl.sv
module pri_ctrl
  import pri_pkg::*;
#(
  parameter bit IS_PRIMARY = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 nestMode,
  input  rank_t                candRank,
  input  rank_t                svcRank,
  output ctrl_strobe_t         strobes,
  output logic                 winValid,
  output logic [PRI_IDX_W-1:0] winLine,
  output logic                 intReq
);
  always_comb begin
    strobes.exemptCascade = IS_PRIMARY && nestMode;
    winValid              = candRank.hit && (candRank.rank < svcRank.rank);
    strobes.loadInt       = winValid;
    winLine               = candRank.line;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intReq <= 1'b0;
    else       intReq <= strobes.loadInt;
  end
endmodule

// File: rtl/nest_prio_resolver.sv
module nest_prio_resolver
  import pri_pkg::*;
#(
  parameter int CASCADE_LINE = 2,
  parameter bit IS_PRIMARY   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PRI_LINES-1:0] pendVec,
  input  logic [PRI_LINES-1:0] maskVec,
  input  logic [PRI_LINES-1:0] svcVec,
  input  logic [PRI_IDX_W-1:0] rotBase,
  input  logic                 nestMode,
  input  logic [PRI_LINES-1:0] probeVec,
  output logic                 winValid,
  output logic [PRI_IDX_W-1:0] winLine,
  output logic                 probeValid,
  output logic [PRI_IDX_W-1:0] probeLine,
  output logic                 intReq
);
  ctrl_strobe_t strobes;
  rank_t        candRank, svcRank, probeRank;

  pri_datapath #(.CASCADE_LINE(CASCADE_LINE)) u_dp (
    .pendVec   (pendVec),
    .maskVec   (maskVec),
    .svcVec    (svcVec),
    .probeVec  (probeVec),
    .rotBase   (rotBase),
    .strobes   (strobes),
    .candRank  (candRank),
    .svcRank   (svcRank),
    .probeRank (probeRank)
  );

  pri_ctrl #(.IS_PRIMARY(IS_PRIMARY)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .nestMode (nestMode),
    .candRank (candRank),
    .svcRank  (svcRank),
    .strobes  (strobes),
    .winValid (winValid),
    .winLine  (winLine),
    .intReq   (intReq)
  );

  assign probeValid = probeRank.hit;
  assign probeLine  = probeRank.line;
endmodule

// File: rtl/nest_prio_resolver_chk.sv
module nest_prio_resolver_chk
  import pri_pkg::*;
#(
  parameter int CASCADE_LINE = 2,
  parameter bit IS_PRIMARY   = 1'b1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [PRI_LINES-1:0] pendVec,
  input logic [PRI_LINES-1:0] maskVec,
  input logic [PRI_LINES-1:0] svcVec,
  input logic [PRI_IDX_W-1:0] rotBase,
  input logic                 nestMode,
  input logic [PRI_LINES-1:0] probeVec,
  input logic                 winValid,
  input logic [PRI_IDX_W-1:0] winLine,
  input logic                 probeValid,
  input logic [PRI_IDX_W-1:0] probeLine,
  input logic                 intReq
);
  // R1
  base_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec[rotBase] && !maskVec[rotBase] && svcVec == '0) |-> (winValid && winLine == rotBase));
  // R2
  no_cand_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & ~maskVec) == '0) |-> !winValid);
  // R3
  masked_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (pendVec[winLine] && !maskVec[winLine]));
  // R4
  svc_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && !(IS_PRIMARY && nestMode && winLine == PRI_IDX_W'(CASCADE_LINE))) |-> !svcVec[winLine]);
  // R5
  empty_svc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (svcVec == '0 && (pendVec & ~maskVec) != '0) |-> winValid);
  // R7
  probe_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    probeValid == (probeVec != '0));
  // R7
  probe_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    probeValid |-> probeVec[probeLine]);
  // R8
  int_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (intReq == $past(winValid)));
endmodule

bind nest_prio_resolver nest_prio_resolver_chk #(
  .CASCADE_LINE(CASCADE_LINE),
  .IS_PRIMARY  (IS_PRIMARY)
) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pendVec    (pendVec),
  .maskVec    (maskVec),
  .svcVec     (svcVec),
  .rotBase    (rotBase),
  .nestMode   (nestMode),
  .probeVec   (probeVec),
  .winValid   (winValid),
  .winLine    (winLine),
  .probeValid (probeValid),
  .probeLine  (probeLine),
  .intReq     (intReq)
);

// File: tb/test_nest_prio_resolver.sv
module test_nest_prio_resolver;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pendVec = '0, maskVec = '0, svcVec = '0, probeVec = '0;
  logic [2:0] rotBase = '0;
  logic       nestMode = 1'b0;
  logic       winValid, probeValid, intReq;
  logic [2:0] winLine, probeLine;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic       v;
    logic [2:0] l;
    logic       pv;
    logic [2:0] pl;
    string      tag;
  } exp_t;
  exp_t sbQ[$];

  always #10 clk = ~clk;

  nest_prio_resolver i_nest_prio_resolver (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .maskVec(maskVec), .svcVec(svcVec),
    .rotBase(rotBase), .nestMode(nestMode), .probeVec(probeVec),
    .winValid(winValid), .winLine(winLine), .probeValid(probeValid),
    .probeLine(probeLine), .intReq(intReq)
  );

  // rank of line n under base b
  function automatic int rankOf(int n, int b);
    return (n - b + 8) % 8;
  endfunction

  // best-ranked set bit; returns 8 when the vector is empty
  function automatic int bestRank(logic [7:0] v, int b, output int line);
    int best = 8;
    line = 0;
    for (int n = 0; n < 8; n++)
      if (v[n] && rankOf(n, b) < best) begin
        best = rankOf(n, b);
        line = n;
      end
    return best;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [7:0] p, logic [7:0] m, logic [7:0] s, logic [2:0] b,
                       logic n, logic [7:0] q, string tag);
    exp_t e;
    int cl, sl, pl, cr, sr, pr;
    logic [7:0] sEff;
    @(negedge clk);
    pendVec = p; maskVec = m; svcVec = s; rotBase = b; nestMode = n; probeVec = q;
    sEff = n ? (s & 8'hFB) : s;
    cr = bestRank(p & ~m, b, cl);
    sr = bestRank(sEff, b, sl);
    pr = bestRank(q, b, pl);
    e.v   = (cr < 8) && (cr < sr);
    e.l   = 3'(cl);
    e.pv  = (pr < 8);
    e.pl  = 3'(pl);
    e.tag = tag;
    sbQ.push_back(e);
  endtask

  // monitor: after each rising edge, inputs from the prior falling edge are stable
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sbQ.size() > 0) begin
        e = sbQ.pop_front();
        check({e.tag, " R1/R4 winValid"}, {7'd0, winValid}, {7'd0, e.v});
        if (e.v) check({e.tag, " R1 winLine"}, {5'd0, winLine}, {5'd0, e.l});
        check({e.tag, " R7 probeValid"}, {7'd0, probeValid}, {7'd0, e.pv});
        if (e.pv) check({e.tag, " R7 probeLine"}, {5'd0, probeLine}, {5'd0, e.pl});
        check({e.tag, " R8 intReq"}, {7'd0, intReq}, {7'd0, e.v});
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1ACE_B00C;
    // R8: reset holds intReq low even with a live candidate
    pendVec = 8'h01;
    repeat (3) @(negedge clk);
    check("R8 reset intReq", {7'd0, intReq}, 8'd0);
    check("R8 reset winValid comb", {7'd0, winValid}, 8'd1);
    rstN = 1'b1;

    // R1, R9: lone candidate on each line under every base
    for (int b = 0; b < 8; b++)
      for (int l = 0; l < 8; l++)
        apply(8'(1 << l), 8'h00, 8'h00, 3'(b), 1'b0, 8'(1 << ((l + 3) % 8)), "R1 lone R9");
    // R1, R9: all pending; base line must win
    for (int b = 0; b < 8; b++) apply(8'hFF, 8'h00, 8'h00, 3'(b), 1'b0, 8'hFF, "R1 all R9");
    // R2: nothing pending, and everything masked
    apply(8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 8'h00, "R2 empty");
    apply(8'hFF, 8'hFF, 8'h00, 3'd5, 1'b0, 8'h00, "R2 masked");
    // R3: only one unmasked line
    apply(8'hFF, 8'hEF, 8'h00, 3'd0, 1'b0, 8'h10, "R3 one open");
    apply(8'h0F, 8'hF3, 8'h00, 3'd6, 1'b0, 8'h30, "R3 partial");
    // R4: equal, better and worse in-service rank
    apply(8'h08, 8'h00, 8'h08, 3'd0, 1'b0, 8'h08, "R4 equal");
    apply(8'h08, 8'h00, 8'h02, 3'd0, 1'b0, 8'h02, "R4 svc better");
    apply(8'h08, 8'h00, 8'h20, 3'd0, 1'b0, 8'h20, "R4 svc worse");
    apply(8'h01, 8'h00, 8'h80, 3'd1, 1'b0, 8'h81, "R4 wrap");
    // R5: empty in-service lets any candidate through
    apply(8'h80, 8'h00, 8'h00, 3'd0, 1'b0, 8'h80, "R5 worst line");
    // R6: cascade line in service, nest off then on
    apply(8'h04, 8'h00, 8'h04, 3'd0, 1'b0, 8'h04, "R6 nest off");
    apply(8'h04, 8'h00, 8'h04, 3'd0, 1'b1, 8'h04, "R6 nest on");
    apply(8'h08, 8'h00, 8'h04, 3'd2, 1'b0, 8'h00, "R6 off rank");
    apply(8'h08, 8'h00, 8'h04, 3'd2, 1'b1, 8'h00, "R6 on rank");
    apply(8'h08, 8'h00, 8'h06, 3'd1, 1'b1, 8'h06, "R6 other svc");
    // R9: pseudo-random sweep over every base
    for (int i = 0; i < 800; i++) begin
      logic [7:0] p, m, s, q;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; p = lfsr[7:0]; m = lfsr[15:8] & lfsr[23:16];
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; s = lfsr[7:0] & lfsr[11:4]; q = lfsr[23:16];
      apply(p, m, s, 3'(i % 8), lfsr[30], q, "R9 sweep");
    end
    @(negedge clk);
    wait (sbQ.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule